// File: doc/BRIEF.md
# Bus Cycle Controller with Dynamic Bus Sizing

This block is the bus-master sequencer of a processor core. It accepts one transfer request at a time: a word address, four lane enables, direction, data/control and memory/I-O kind, and the write data. It then runs a single non-pipelined bus cycle. At the start of the cycle it drives an active-low address strobe for one execution-clock period, which marks the address, byte enables and cycle-type lines as valid. It then holds everything steady through any number of wait states until an active-low ready input is sampled low. On a read it captures the data bus on that sample.

The block runs from a double-rate input clock and advances its state only on every second edge, so its execution clock is the input clock divided by two. When the ready sample also finds the bus-size input low, the responding device is 16 bits wide. If the request enabled lane 2 or lane 3, the controller then runs a second cycle at the same address. That second cycle enables only the two low byte enables, carries the upper write half on data lines 15:0, and takes the upper read half from those same lines. After reset releases, the first cycle the block runs is a code fetch from the reset vector, ahead of any request.

Top module: `bus_cycle_ctl`

## Requirements
- R1: During a bus cycle `addr` equals the requested word address, `be_n` is the bitwise inverse of `req_be` (bit i low enables byte lane i, data bits 8i+7:8i), `cyc_write` is high for a write and low for a read, `cyc_data` is high for data and low for control, and `cyc_mem` is high for memory and low for I/O.
- R2: `ads_n` is low for exactly two input-clock periods (one execution-clock period) at the start of every bus cycle, including a second halfword cycle.
- R3: From the strobe until ready is sampled low, the address, byte enables, cycle type and `dout` stay unchanged, and wait states continue for as long as `ready_n` is sampled high.
- R4: On a read with `bs16_n` sampled high together with ready, `rdata` takes all 32 bits of `din`.
- R5: On a write, the first cycle drives the full request word on `dout`.
- R6: When `bs16_n` is sampled low together with ready and `req_be[2]` or `req_be[3]` is set, a second cycle follows at once with `be_n[3:2]` = 2'b11, `be_n[1:0]` = inverse of `req_be[3:2]`, and `dout[15:0]` = upper write half. A read then assembles `rdata[15:0]` from `din[15:0]` of the first cycle and `rdata[31:16]` from `din[15:0]` of the second.
- R7: No second cycle is run when `bs16_n` is sampled low and only lanes 0 and 1 are enabled. `bs16_n` has no effect during the second cycle.
- R8: `done` goes high for exactly two input-clock periods after the final ready sample and never between the halves of a split transfer. `busy` is high from acceptance until that point.
- R9: While `rst` is high, `ads_n` is high, `be_n` is 4'b1111 and `done` is low, even when reset arrives in the middle of a cycle. The first cycle after reset is a memory code read (`cyc_write`=0, `cyc_data`=0, `cyc_mem`=1) of all four lanes at byte address FFFF_FFF0h.
- R10: A cycle with w wait states lasts 4+2w input-clock periods from the strobe falling to `done` (or to the next half's strobe).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate input clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request, sampled while idle |
| req_addr | input | 30 | Requested word address (bits 31:2) |
| req_be | input | 4 | Requested byte lanes, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data, 0 = control |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request accepted or cycle in progress |
| done | output | 1 | Transfer finished, two input clocks wide |
| rdata | output | 32 | Read data captured on ready |
| ads_n | output | 1 | Address strobe, active low |
| addr | output | 30 | Bus word address |
| be_n | output | 4 | Byte enables, active low |
| cyc_write | output | 1 | Cycle type: write/read |
| cyc_data | output | 1 | Cycle type: data/control |
| cyc_mem | output | 1 | Cycle type: memory/I-O |
| dout | output | 32 | Data driven onto the bus |
| din | input | 32 | Data read from the bus |
| ready_n | input | 1 | Transfer acknowledge, active low |
| bs16_n | input | 1 | Bus size: low = 16-bit device |

## Verification
The bench sweeps every non-zero lane pattern for both directions, both bus widths and several wait-state counts, and checks each address phase against arithmetically derived fields. Upper-only lane patterns on a narrow device must still split into two cycles; a design that keyed the split on the low lanes would finish early with the upper half unread. Low-only narrow transfers must finish in one cycle; a design that always split would add a spurious strobe. During the second half `bs16_n` is driven high and the upper `din` bits carry junk, so a design that re-sampled the width or read the wrong lanes would corrupt `rdata`. A reset in the middle of a wait state must return the strobe and enables to idle and restart with the reset-vector fetch. A design that counted wait states on the input clock instead of the divided clock would show the wrong strobe width and cycle length.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2
   } bcc_state_e;

   typedef struct packed {
      logic wr;
      logic dc;
      logic mio;
   } bcc_kind_t;

endpackage

// File: rtl/bcc_clkdiv.sv
module bcc_clkdiv (
   input  logic clk2,
   input  logic rst,
   output logic tick
);

   logic phase_q;

   always_ff @(posedge clk2) begin
      if (rst) phase_q <= 1'b0;
      else     phase_q <= ~phase_q;
   end

   assign tick = phase_q;

   // R10
   tick_alt_chk: assert property (@(posedge clk2) disable iff (rst)
      tick |=> !tick);

endmodule

// File: rtl/bcc_steer.sv
module bcc_steer #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                upper,
   input  logic                bs16_n,
   input  logic [DATA_W-1:0]   din,
   input  logic [DATA_W-1:0]   rdata_cur,
   output logic [DATA_W/8-1:0] be_n_o,
   output logic [DATA_W-1:0]   dout,
   output logic [DATA_W-1:0]   rdata_nxt,
   output logic                need_upper
);

   localparam int LANES  = DATA_W / 8;
   localparam int HLANES = LANES / 2;
   localparam int HALF_W = DATA_W / 2;

   logic [HLANES-1:0] hi_lanes;
   logic [HALF_W-1:0] w_hi;

   assign hi_lanes = be[LANES-1:HLANES];
   assign w_hi     = wdata[DATA_W-1:HALF_W];

   always_comb begin
      if (upper) begin
         be_n_o = ~{{HLANES{1'b0}}, hi_lanes};
         dout   = {w_hi, w_hi};
      end else begin
         be_n_o = ~be;
         dout   = wdata;
      end
   end

   always_comb begin
      if (upper)
         rdata_nxt = {din[HALF_W-1:0], rdata_cur[HALF_W-1:0]};
      else if (!bs16_n)
         rdata_nxt = {rdata_cur[DATA_W-1:HALF_W], din[HALF_W-1:0]};
      else
         rdata_nxt = din;
   end

   assign need_upper = !upper && !bs16_n && (|hi_lanes);

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
   import bcc_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          DATA_W       = 32,
   parameter logic [31:0] RESET_VECTOR = 32'hFFFF_FFF0,
   parameter bit          BOOT_FETCH   = 1'b1
) (
   input  logic                 clk2,
   input  logic                 rst,
   input  logic                 tick,
   input  logic                 req,
   input  logic [ADDR_W-1:2]    req_addr,
   input  logic [DATA_W/8-1:0]  req_be,
   input  bcc_kind_t            req_kind,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic                 ready_n,
   input  logic                 need_upper,
   input  logic [DATA_W-1:0]    rdata_nxt,
   output logic                 ads_n,
   output logic [ADDR_W-1:2]    addr_q,
   output logic [DATA_W/8-1:0]  be_q,
   output bcc_kind_t            kind_q,
   output logic [DATA_W-1:0]    wdata_q,
   output logic                 upper,
   output logic [DATA_W-1:0]    rdata,
   output logic                 done,
   output logic                 busy
);

   localparam int LANES = DATA_W / 8;
   localparam logic [ADDR_W-1:2] VEC_WORD = RESET_VECTOR[ADDR_W-1:2];
   localparam bcc_kind_t FETCH_KIND = '{wr: 1'b0, dc: 1'b0, mio: 1'b1};

   bcc_state_e state;
   logic       boot_pend;
   logic       boot_init;

   generate
      if (BOOT_FETCH) begin : g_boot
         assign boot_init = 1'b1;
      end else begin : g_noboot
         assign boot_init = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk2) begin
      if (rst) begin
         state     <= ST_IDLE;
         ads_n     <= 1'b1;
         upper     <= 1'b0;
         done      <= 1'b0;
         boot_pend <= boot_init;
         addr_q    <= '0;
         be_q      <= '0;
         kind_q    <= '0;
         wdata_q   <= '0;
         rdata     <= '0;
      end else if (tick) begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (boot_pend) begin
                  boot_pend <= 1'b0;
                  addr_q    <= VEC_WORD;
                  be_q      <= {LANES{1'b1}};
                  kind_q    <= FETCH_KIND;
                  wdata_q   <= '0;
                  upper     <= 1'b0;
                  ads_n     <= 1'b0;
                  state     <= ST_ADDR;
               end else if (req) begin
                  addr_q    <= req_addr;
                  be_q      <= req_be;
                  kind_q    <= req_kind;
                  wdata_q   <= req_wdata;
                  upper     <= 1'b0;
                  ads_n     <= 1'b0;
                  state     <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               ads_n <= 1'b1;
               state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (!ready_n) begin
                  if (!kind_q.wr) rdata <= rdata_nxt;
                  if (need_upper) begin
                     upper <= 1'b1;
                     ads_n <= 1'b0;
                     state <= ST_ADDR;
                  end else begin
                     upper <= 1'b0;
                     be_q  <= '0;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = boot_pend || (state != ST_IDLE);

   // R2
   ads_pulse_chk: assert property (@(posedge clk2) disable iff (rst)
      $fell(ads_n) |=> !ads_n ##1 ads_n);

   // R3
   wait_hold_chk: assert property (@(posedge clk2) disable iff (rst)
      (state == ST_WAIT && $past(state) == ST_WAIT) |->
         ($stable(addr_q) && $stable(be_q) && $stable(kind_q) &&
          $stable(wdata_q) && $stable(upper)));

   // R8
   done_pulse_chk: assert property (@(posedge clk2) disable iff (rst)
      $rose(done) |=> done ##1 !done);

   // R6
   upper_strobe_chk: assert property (@(posedge clk2) disable iff (rst)
      $rose(upper) |-> (!ads_n && state == ST_ADDR));

   // R8
   idle_quiet_chk: assert property (@(posedge clk2) disable iff (rst)
      (state == ST_IDLE) |-> (ads_n && !upper));

endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
   import bcc_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          DATA_W       = 32,
   parameter logic [31:0] RESET_VECTOR = 32'hFFFF_FFF0,
   parameter bit          BOOT_FETCH   = 1'b1
) (
   input  logic                clk2,
   input  logic                rst,
   input  logic                req,
   input  logic [ADDR_W-1:2]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic                req_write,
   input  logic                req_data,
   input  logic                req_mem,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                busy,
   output logic                done,
   output logic [DATA_W-1:0]   rdata,
   output logic                ads_n,
   output logic [ADDR_W-1:2]   addr,
   output logic [DATA_W/8-1:0] be_n,
   output logic                cyc_write,
   output logic                cyc_data,
   output logic                cyc_mem,
   output logic [DATA_W-1:0]   dout,
   input  logic [DATA_W-1:0]   din,
   input  logic                ready_n,
   input  logic                bs16_n
);

   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_data_w
         $error("bus_cycle_ctl: DATA_W must be a multiple of 16");
      end
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr_w
         $error("bus_cycle_ctl: ADDR_W must lie in 3..32");
      end
   endgenerate

   logic              tick;
   logic [LANES-1:0]  be_q;
   bcc_kind_t         kind_q;
   bcc_kind_t         req_kind;
   logic [DATA_W-1:0] wdata_q;
   logic              upper;
   logic              need_upper;
   logic [DATA_W-1:0] rdata_nxt;

   assign req_kind = '{wr: req_write, dc: req_data, mio: req_mem};

   bcc_clkdiv u_div (
      .clk2 (clk2),
      .rst  (rst),
      .tick (tick)
   );

   bcc_seq #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .RESET_VECTOR (RESET_VECTOR),
      .BOOT_FETCH   (BOOT_FETCH)
   ) u_seq (
      .clk2       (clk2),
      .rst        (rst),
      .tick       (tick),
      .req        (req),
      .req_addr   (req_addr),
      .req_be     (req_be),
      .req_kind   (req_kind),
      .req_wdata  (req_wdata),
      .ready_n    (ready_n),
      .need_upper (need_upper),
      .rdata_nxt  (rdata_nxt),
      .ads_n      (ads_n),
      .addr_q     (addr),
      .be_q       (be_q),
      .kind_q     (kind_q),
      .wdata_q    (wdata_q),
      .upper      (upper),
      .rdata      (rdata),
      .done       (done),
      .busy       (busy)
   );

   bcc_steer #(
      .DATA_W (DATA_W)
   ) u_steer (
      .be         (be_q),
      .wdata      (wdata_q),
      .upper      (upper),
      .bs16_n     (bs16_n),
      .din        (din),
      .rdata_cur  (rdata),
      .be_n_o     (be_n),
      .dout       (dout),
      .rdata_nxt  (rdata_nxt),
      .need_upper (need_upper)
   );

   assign cyc_write = kind_q.wr;
   assign cyc_data  = kind_q.dc;
   assign cyc_mem   = kind_q.mio;

endmodule

// File: tb/bus_cycle_ctl_test.sv
module bus_cycle_ctl_test;

   logic        clk2 = 1'b0;
   logic        rst  = 1'b1;
   logic        req  = 1'b0;
   logic [31:2] req_addr  = '0;
   logic [3:0]  req_be    = '0;
   logic        req_write = 1'b0;
   logic        req_data  = 1'b0;
   logic        req_mem   = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        busy, done, ads_n, cyc_write, cyc_data, cyc_mem;
   logic [31:0] rdata, dout;
   logic [31:2] addr;
   logic [3:0]  be_n;
   logic [31:0] din     = 32'hDEAD_BEEF;
   logic        ready_n = 1'b1;
   logic        bs16_n  = 1'b1;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #5 clk2 = ~clk2;

   bus_cycle_ctl uut (
      .clk2 (clk2), .rst (rst), .req (req), .req_addr (req_addr),
      .req_be (req_be), .req_write (req_write), .req_data (req_data),
      .req_mem (req_mem), .req_wdata (req_wdata), .busy (busy),
      .done (done), .rdata (rdata), .ads_n (ads_n), .addr (addr),
      .be_n (be_n), .cyc_write (cyc_write), .cyc_data (cyc_data),
      .cyc_mem (cyc_mem), .dout (dout), .din (din), .ready_n (ready_n),
      .bs16_n (bs16_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One complete transfer; use_req=0 expects the self-issued reset fetch.
   task automatic xfer(input bit use_req, input logic [29:0] a,
                       input logic [3:0] be, input logic w, input logic dc,
                       input logic m, input logic [31:0] wd, input int ws,
                       input logic narrow, input logic [31:0] d0,
                       input logic [31:0] d1);
      int nh, cnt, tot;
      logic [31:0] exp_rd, mask;
      logic [3:0]  exp_be_n;
      logic [31:0] exp_do;
      nh = (narrow && (be[3] || be[2])) ? 2 : 1;
      if (use_req) begin
         req_addr = a; req_be = be; req_write = w; req_data = dc;
         req_mem = m; req_wdata = wd; req = 1'b1;
      end
      tot = 0;
      while (ads_n) @(negedge clk2);
      req = 1'b0;
      for (int h = 0; h < nh; h++) begin
         while (ads_n) begin @(negedge clk2); tot++; end
         exp_be_n = (h == 0) ? ~be : {2'b11, ~be[3:2]};
         exp_do   = (h == 0) ? wd : {wd[31:16], wd[31:16]};
         // R1 address and cycle type
         chk(addr == a, "R1 addr", {2'b00, addr}, {2'b00, a});
         chk({cyc_write, cyc_data, cyc_mem} == {w, dc, m}, "R1 type",
             {29'd0, cyc_write, cyc_data, cyc_mem}, {29'd0, w, dc, m});
         // R1 / R6 enables
         chk(be_n == exp_be_n, (h == 0) ? "R1 be_n" : "R6 be_n",
             {28'd0, be_n}, {28'd0, exp_be_n});
         // R5 / R6 write data
         if (w) chk(dout == exp_do, (h == 0) ? "R5 dout" : "R6 dout",
                    dout, exp_do);
         cnt = 0;
         while (!ads_n) begin cnt++; @(negedge clk2); tot++; end
         // R2 strobe width
         chk(cnt == 2, "R2 strobe width", cnt, 2);
         for (int k = 0; k < 2 * ws; k++) begin
            // R3 hold during wait states
            chk(addr == a && be_n == exp_be_n && busy && !done &&
                cyc_write == w && (!w || dout == exp_do), "R3 hold",
                {be_n, busy, done, 26'd0}, {exp_be_n, 1'b1, 1'b0, 26'd0});
            @(negedge clk2); tot++;
         end
         din     = (h == 0) ? d0 : d1;
         bs16_n  = (h == 0) ? !narrow : 1'b1;
         ready_n = 1'b0;
         @(negedge clk2); tot++;
         @(negedge clk2); tot++;
         ready_n = 1'b1;
         bs16_n  = 1'b1;
         din     = 32'hDEAD_BEEF;
         // R10 cycle length
         chk(tot == (h + 1) * (4 + 2 * ws), "R10 length", tot,
             (h + 1) * (4 + 2 * ws));
         if (h < nh - 1) chk(!done, "R8 no done between halves", done, 0);
      end
      // R7 / R8 completion
      chk(done && !busy, (narrow && nh == 1) ? "R7 single cycle" : "R8 done",
          {30'd0, done, busy}, 32'd2);
      if (!w) begin
         mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
         if (nh == 2)     exp_rd = {d1[15:0], d0[15:0]};
         else if (narrow) exp_rd = {16'd0, d0[15:0]};
         else             exp_rd = d0;
         chk((rdata & mask) == (exp_rd & mask),
             (nh == 2) ? "R6 R7 rdata" : "R4 rdata",
             rdata & mask, exp_rd & mask);
      end
      @(negedge clk2);
      chk(done, "R8 done width", done, 1);
      @(negedge clk2);
      chk(!done, "R8 done width", done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk2);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20) @(negedge clk2);
      // R9 idle during reset
      chk(ads_n && be_n == 4'hF && !done, "R9 reset idle",
          {27'd0, ads_n, be_n}, {27'd0, 1'b1, 4'hF});
      rst = 1'b0;
      // R9 reset-vector code fetch
      xfer(1'b0, 30'h3FFF_FFFC, 4'hF, 1'b0, 1'b0, 1'b1, 32'd0, 1, 1'b0,
           32'h1234_5678, 32'h0);

      for (int b = 1; b < 16; b++) begin
         for (int nw = 0; nw < 2; nw++) begin
            for (int wr = 0; wr < 2; wr++) begin
               xfer(1'b1, 30'(32'h0040_0000 + b * 7 + nw * 3 + wr),
                    4'(b), wr[0], b[0], b[1],
                    32'h0101_0101 * b + 32'hA5A5_0000 * (nw + 1),
                    (b + nw + wr) % 3, nw[0],
                    32'hC300_0000 + 32'h0001_1111 * b,
                    32'h5A5A_0000 + 32'h0000_0F0F * b);
            end
         end
      end

      // R9 reset in the middle of a wait state
      req_addr = 30'h0000_1234; req_be = 4'hF; req_write = 1'b1;
      req_data = 1'b1; req_mem = 1'b1; req_wdata = 32'hFACE_CAFE; req = 1'b1;
      while (ads_n) @(negedge clk2);
      req = 1'b0;
      repeat (6) @(negedge clk2);
      rst = 1'b1;
      repeat (16) @(negedge clk2);
      chk(ads_n && be_n == 4'hF && !done, "R9 reset mid cycle",
          {27'd0, ads_n, be_n}, {27'd0, 1'b1, 4'hF});
      rst = 1'b0;
      xfer(1'b0, 30'h3FFF_FFFC, 4'hF, 1'b0, 1'b0, 1'b1, 32'd0, 0, 1'b0,
           32'h0BAD_F00D, 32'h0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule